// File: doc/BRIEF.md
# Triggered Sawtooth Code Generator

This block produces the 12-bit digital code for one converter channel. When its wave-mode field selects sawtooth, the code is held in an internal register. Two trigger inputs act on that register, and each has its own source select. A reload event writes the programmed start value into the register. A step event adds the programmed step to the register when the direction bit is 1, or subtracts it when the direction bit is 0. The result always wraps within 12 bits.

In every other wave mode the block acts as a pass-through. The code follows the holding-data input one clock later, and all triggers are ignored. Each trigger source passes through a rising-edge detector, so a level held high counts only once. Every sawtooth update raises the valid strobe for exactly one cycle.

The output has no back-pressure. There is no ready input. The strobe marks the cycle after an update, and the code then holds its value until the next event. A consumer must therefore take each value while the strobe is high, or read the held code at any later time.

Top module: `saw_wave_gen`

## Requirements
- R1: While reset is asserted, the code output is 0 and the valid strobe is 0.
- R2: The wave-mode field uses these codes: 2'b00 off, 2'b01 noise, 2'b10 triangle, 2'b11 sawtooth. In the three non-sawtooth modes, the code equals the holding-data input from the previous cycle, the strobe stays 0, and trigger events change nothing.
- R3: In sawtooth mode, a reload event makes the code equal to the start value one clock later.
- R4: In sawtooth mode with the direction bit at 1, a step event adds the step value to the code.
- R5: In sawtooth mode with the direction bit at 0, a step event subtracts the step value from the code.
- R6: Additions and subtractions wrap modulo 4096.
- R7: When a reload event and a step event occur in the same cycle, only the reload takes effect. This includes the case where both selects name the same source.
- R8: An event occurs only on a rising edge of the selected source. A source held high for several cycles produces a single event.
- R9: Select code 0 picks the software trigger input of its own role (reload or step). Select code k, for k of 1 or more, picks hardware line hw_trig[k]. Sources that are not selected are ignored.
- R10: Every sawtooth update raises the strobe for exactly one cycle, in the cycle where the new code first appears. Between events the code does not change and the strobe is 0.
- R11: On a switch into sawtooth mode, stepping continues from the last pass-through code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_mode | input | 2 | Wave-mode select (2'b11 = sawtooth) |
| start_val | input | CODE_W | Value loaded by a reload event |
| step_val | input | CODE_W | Amount added or subtracted per step event |
| dir_up | input | 1 | 1 = add, 0 = subtract |
| hold_data | input | CODE_W | Code passed through in non-sawtooth modes |
| reload_sel | input | SEL_W | Source select for the reload trigger |
| step_sel | input | SEL_W | Source select for the step trigger |
| sw_reload | input | 1 | Software reload trigger (select code 0) |
| sw_step | input | 1 | Software step trigger (select code 0) |
| hw_trig | input | NSRC-1 | Hardware trigger lines, indexed 1 to NSRC-1 |
| code_out | output | CODE_W | Current output code |
| code_valid | output | 1 | One-cycle strobe after each sawtooth update |

## Verification
Reload and step can fall in the same clock. The bench provokes this in two ways. First, it pulses both software triggers together with both selects at 0. Second, it points both selects at one hardware line and pulses that line. In both cases the scoreboard expects one strobe that carries the start value and no step applied. The stepped result is judged wrong.

// File: rtl/saw_pkg.sv
package saw_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_NOISE = 2'b01,
    WM_TRI   = 2'b10,
    WM_SAW   = 2'b11
  } wave_mode_e;
endpackage

// File: rtl/saw_trig_pick.sv
module saw_trig_pick #(
  parameter int NSRC = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_lvl,
  input  logic [NSRC-1:1]  hw_lvl,
  input  logic [SEL_W-1:0] sel,
  output logic             evt
);
  logic [NSRC-1:0] lvl;
  logic [NSRC-1:0] rise;

  assign lvl = {hw_lvl, sw_lvl};

  // one edge detector per source, so changing the select never fabricates an edge
  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    logic lvl_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q;
  end

  always_comb begin
    evt = 1'b0;
    if (int'(sel) < NSRC) evt = rise[sel];
  end
endmodule

// File: rtl/saw_step_unit.sv
module saw_step_unit #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              saw_on,
  input  logic              reload_evt,
  input  logic              step_evt,
  input  logic              dir_up,
  input  logic [CODE_W-1:0] start_val,
  input  logic [CODE_W-1:0] step_val,
  input  logic [CODE_W-1:0] hold_data,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  logic [CODE_W-1:0] stepped;

  assign stepped = dir_up ? code + step_val : code - step_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (!saw_on) begin
      code  <= hold_data;
      valid <= 1'b0;
    end else if (reload_evt) begin
      code  <= start_val;
      valid <= 1'b1;
    end else if (step_evt) begin
      code  <= stepped;
      valid <= 1'b1;
    end else begin
      valid <= 1'b0;
    end
  end

  // R3 R7
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    saw_on && reload_evt |=> code == $past(start_val) && valid);

  // R4 R5 R6
  step_math_chk: assert property (@(posedge clk) disable iff (!rst_n)
    saw_on && !reload_evt && step_evt |=>
      code == ($past(dir_up) ? CODE_W'($past(code) + $past(step_val))
                             : CODE_W'($past(code) - $past(step_val))));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !saw_on |=> code == $past(hold_data) && !valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    saw_on && !reload_evt && !step_evt |=> $stable(code) && !valid);
endmodule

// File: rtl/saw_wave_gen.sv
module saw_wave_gen #(
  parameter int CODE_W = 12,
  parameter int NSRC = 16,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wave_mode,
  input  logic [CODE_W-1:0] start_val,
  input  logic [CODE_W-1:0] step_val,
  input  logic              dir_up,
  input  logic [CODE_W-1:0] hold_data,
  input  logic [SEL_W-1:0]  reload_sel,
  input  logic [SEL_W-1:0]  step_sel,
  input  logic              sw_reload,
  input  logic              sw_step,
  input  logic [NSRC-1:1]   hw_trig,
  output logic [CODE_W-1:0] code_out,
  output logic              code_valid
);
  import saw_pkg::*;

  logic reload_evt, step_evt, saw_on;

  assign saw_on = (wave_mode == WM_SAW);

  saw_trig_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_reload_pick (
    .clk(clk), .rst_n(rst_n), .sw_lvl(sw_reload), .hw_lvl(hw_trig),
    .sel(reload_sel), .evt(reload_evt)
  );

  saw_trig_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_step_pick (
    .clk(clk), .rst_n(rst_n), .sw_lvl(sw_step), .hw_lvl(hw_trig),
    .sel(step_sel), .evt(step_evt)
  );

  saw_step_unit #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst_n(rst_n), .saw_on(saw_on),
    .reload_evt(reload_evt), .step_evt(step_evt), .dir_up(dir_up),
    .start_val(start_val), .step_val(step_val), .hold_data(hold_data),
    .code(code_out), .valid(code_valid)
  );

  // R8
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_evt) && step_sel == $past(step_sel) && $stable(sw_step) && $stable(hw_trig)
      |-> !step_evt);
endmodule

// File: tb/tb_saw_wave_gen.sv
`timescale 1ns/1ps
module tb_saw_wave_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [11:0] start = '0, step = '0, hold = '0;
  logic        dir = 1'b1;
  logic [3:0]  rsel = '0, isel = '0;
  logic        swr = 1'b0, swi = 1'b0;
  logic [15:1] hw = '0;
  logic [11:0] code;
  logic        valid;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [11:0] expq[$];
  string tagq[$];
  logic [11:0] m;

  always #4 clk = ~clk;

  saw_wave_gen dut (
    .clk(clk), .rst_n(rst_n), .wave_mode(mode), .start_val(start), .step_val(step),
    .dir_up(dir), .hold_data(hold), .reload_sel(rsel), .step_sel(isel),
    .sw_reload(swr), .sw_step(swi), .hw_trig(hw), .code_out(code), .code_valid(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sr, input bit si, input int hk, input string tag);
    bit re, ie;
    logic [11:0] e;
    re = (rsel == 0 && sr) || (hk != 0 && int'(rsel) == hk);
    ie = (isel == 0 && si) || (hk != 0 && int'(isel) == hk);
    if (mode == 2'b11 && (re || ie)) begin
      e = re ? start : (dir ? m + step : m - step);
      expq.push_back(e);
      tagq.push_back(tag);
      m = e;
    end
    swr = sr; swi = si;
    if (hk != 0) hw[hk] = 1'b1;
    @(negedge clk);
    swr = 1'b0; swi = 1'b0; hw = '0;
    @(negedge clk);
  endtask

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (expq.size() == 0) chk(1'b0, "R10 unexpected strobe", code, 0);
      else begin
        logic [11:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(code == e, t, code, e);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(code == 12'h0 && !valid, "R1 reset state", {valid, code}, 0);
    rst_n = 1'b1;

    // pass-through modes
    hold = 12'h123; repeat (2) @(negedge clk);
    chk(code == 12'h123 && !valid, "R2 off mode follows hold", code, 12'h123);
    pulse(1, 1, 0, "R2 triggers ignored");
    chk(code == 12'h123, "R2 triggers ignored when off", code, 12'h123);
    mode = 2'b01; hold = 12'h456; repeat (2) @(negedge clk);
    chk(code == 12'h456, "R2 noise mode follows hold", code, 12'h456);
    mode = 2'b10; hold = 12'h789; repeat (2) @(negedge clk);
    chk(code == 12'h789, "R2 triangle mode follows hold", code, 12'h789);

    // sawtooth from the last pass-through code
    m = 12'h789; mode = 2'b11; dir = 1'b1; step = 12'h010;
    pulse(0, 1, 0, "R11 step from pass-through value");
    start = 12'h100;
    pulse(1, 0, 0, "R3 reload start");
    pulse(0, 1, 0, "R4 step up");
    step = 12'h033;
    pulse(0, 1, 0, "R4 step up again");
    repeat (3) @(negedge clk);
    chk(code == m && !valid, "R10 code held between events", code, m);
    dir = 1'b0;
    pulse(0, 1, 0, "R5 step down");

    // wrap both ways
    start = 12'hFF0; step = 12'h020; dir = 1'b1;
    pulse(1, 0, 0, "R3 reload near top");
    pulse(0, 1, 0, "R6 wrap on overflow");
    start = 12'h005; step = 12'h010; dir = 1'b0;
    pulse(1, 0, 0, "R3 reload near bottom");
    pulse(0, 1, 0, "R6 wrap on underflow");

    // same-cycle reload and step
    start = 12'h2A0; dir = 1'b1;
    pulse(1, 1, 0, "R7 reload beats step (software)");

    // hardware source selection
    rsel = 4'd3; isel = 4'd5; step = 12'h00F;
    pulse(0, 0, 5, "R9 step from line 5");
    start = 12'h0C0;
    pulse(0, 0, 3, "R9 reload from line 3");
    pulse(1, 1, 0, "R9 software ignored");
    pulse(0, 0, 7, "R9 unselected line ignored");
    chk(code == m, "R9 unselected sources leave code", code, m);
    rsel = 4'd6; isel = 4'd6; start = 12'h3A3;
    pulse(0, 0, 6, "R7 reload beats step (shared line)");

    // level held high counts once
    rsel = 4'd1; isel = 4'd2; step = 12'h001;
    @(negedge clk);
    expq.push_back(m + step); tagq.push_back("R8 held level single event");
    m = m + step;
    hw[2] = 1'b1;
    repeat (6) @(negedge clk);
    hw = '0;
    repeat (2) @(negedge clk);
    chk(code == m, "R8 held level counted once", code, m);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R10 missing strobe", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule